// File: doc/BRIEF.md
# Multi-Mode DMA Transfer Controller

This block moves a block of words from a peripheral data port into memory without the processor touching the data. Software loads a source pointer, a destination pointer and a word count through a small write-only register port, then writes a control word that picks the transfer mode and starts the block. Each word is first taken from the peripheral into a one-word holding buffer. The controller then asks the processor for the memory bus and writes the word to memory once the bus is granted.

There are three ways to share the bus. Hold mode keeps the bus from the first grant until the last word is written. Yield mode gives the bus back after every word and asks again only when the next word is already in the buffer. Share mode keeps its request up but writes only in the alternate cycles that the processor marks as free. When the count reaches zero, a sticky interrupt line rises. It stays high until software clears it. If the grant is taken away partway through a block, the controller drops its request and later picks up from the word it had reached.

Top module: `xfer_dma`

## Requirements
- R1: `mem_we` is high only in cycles where both `bus_req` and `bus_gnt` are high, and every write puts the word held in the buffer on `mem_wdata`.
- R2: Hold mode (control bits [1:0] = 00, and 11 acts the same) with the peripheral always valid: the first write lands in the first cycle with grant, N writes follow on consecutive cycles, and `bus_req` is low in the cycle after the last write. The request is therefore high for exactly grant latency + N cycles, with a single request for the block.
- R3: Yield mode (control bits [1:0] = 01): `bus_req` is low in the cycle after each write, so an N-word block raises the request exactly N times.
- R4: A request is raised only when a peripheral word is already in the buffer. A word is accepted on `per_valid && per_ready`, and exactly N words are accepted for an N-word block.
- R5: Share mode (control bits [1:0] = 10): no write happens in a cycle with `cpu_slot` high. When `cpu_slot` toggles every cycle, no two writes fall on adjacent cycles.
- R6: Word k of the block is taken from peripheral address src+k and written to dst+k, in order. Control bit 2 enables the source step and bit 3 enables the destination step. With a step bit clear, the matching address stays fixed.
- R7: `irq` rises in the cycle after the write that brings the count to zero. It stays high until a control write with bit 5 set clears it.
- R8: If the grant is withdrawn after the bus has been granted, the controller makes no write while the grant is low and drops `bus_req` in the next cycle. It then requests again and finishes the block with no word lost or repeated.
- R9: Register selects are 0 = source, 1 = destination, 2 = count, 3 = control, and control bit 4 starts a block. A start with a count of zero is ignored, and every register write made while a block is in progress is ignored.
- R10: After reset, `bus_req`, `mem_we`, `per_ready` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| bus_req | output | 1 | Memory bus request to the processor |
| bus_gnt | input | 1 | Memory bus grant from the processor |
| cpu_slot | input | 1 | High in cycles the processor uses memory (share mode) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| per_valid | input | 1 | Peripheral word available |
| per_ready | output | 1 | Controller takes the peripheral word |
| per_data | input | DW | Peripheral word |
| per_addr | output | AW | Current peripheral source address |
| irq | output | 1 | Block-complete interrupt, held until cleared |

## Verification
The bench runs every mode against block lengths of 1, 3 and 6 words, two grant latencies, all four step-bit combinations and a peripheral that leaves gaps. Every write and every peripheral handshake is logged and compared with arithmetic expectations.

Several failure modes are targeted directly. A hold-mode controller that lost a cycle between words, or that released the bus late, would fail the latency + N window check. A yield-mode controller that kept its request across words would show fewer than N request rises. Fetching past the count would show up as extra handshakes.

Grant is also withdrawn partway through blocks in hold and share mode. A design that skipped or repeated the word in flight would leave a gap or a duplicate in the address log. The bench further issues starts with a zero count and register writes during a block. A design that honoured either would issue requests or redirect writes.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        MODE_BURST = 2'b00,
        MODE_STEAL = 2'b01,
        MODE_SHARE = 2'b10,
        MODE_HOLD  = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_OWN  = 2'd2
    } seq_state_e;

    localparam int CTRL_INC_SRC = 2;
    localparam int CTRL_INC_DST = 3;
    localparam int CTRL_GO      = 4;
    localparam int CTRL_CLR     = 5;
    localparam int CTRL_BITS    = 6;

    typedef struct packed {
        xfer_mode_e mode;
        logic       inc_src;
        logic       inc_dst;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [CTRL_BITS-1:0] b);
        ctrl_t c;
        c.mode    = xfer_mode_e'(b[1:0]);
        c.inc_src = b[CTRL_INC_SRC];
        c.inc_dst = b[CTRL_INC_DST];
        return c;
    endfunction

    // Share mode may only write while the processor leaves its slot free.
    function automatic logic slot_free(input xfer_mode_e m, input logic cpu_slot);
        return (m != MODE_SHARE) || !cpu_slot;
    endfunction

    // Yield mode hands the bus back after every single word.
    function automatic logic yields_per_word(input xfer_mode_e m);
        return m == MODE_STEAL;
    endfunction

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
    import dmx_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          fetch_fire,
    input  logic          write_fire,
    output logic          go,
    output ctrl_t         ctrl_q,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] fetch_left,
    output logic          last_word,
    output logic          done_q
);
    localparam logic [AW-1:0] ADDR_STEP = AW'(1);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    logic [CW-1:0] cnt_q;
    logic          cfg_ok;
    reg_sel_e      sel;

    assign sel       = reg_sel_e'(cfg_sel);
    assign cfg_ok    = cfg_we && !busy;
    assign go        = cfg_ok && (sel == SEL_CTRL) && cfg_wdata[CTRL_GO] && (cnt_q != '0);
    assign last_word = (cnt_q == CNT_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            cnt_q      <= '0;
            fetch_left <= '0;
            done_q     <= 1'b0;
        end else begin
            if (cfg_ok) begin
                case (sel)
                    SEL_SRC:  src_q <= cfg_wdata;
                    SEL_DST:  dst_q <= cfg_wdata;
                    SEL_CNT:  cnt_q <= cfg_wdata[CW-1:0];
                    default: begin
                        ctrl_q <= decode_ctrl(cfg_wdata[CTRL_BITS-1:0]);
                        if (cfg_wdata[CTRL_CLR]) done_q <= 1'b0;
                    end
                endcase
            end
            if (go) fetch_left <= cnt_q;
            if (fetch_fire) begin
                fetch_left <= fetch_left - CNT_ONE;
                if (ctrl_q.inc_src) src_q <= src_q + ADDR_STEP;
            end
            if (write_fire) begin
                cnt_q <= cnt_q - CNT_ONE;
                if (ctrl_q.inc_dst) dst_q <= dst_q + ADDR_STEP;
                if (last_word) done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmx_wordbuf.sv
module dmx_wordbuf #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] data_in,
    input  logic          drain,
    output logic          full,
    output logic [DW-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full   <= 1'b1;
            data_q <= data_in;
        end else if (drain) begin
            full   <= 1'b0;
        end
    end

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       buf_full,
    input  logic       bus_gnt,
    input  logic       cpu_slot,
    input  xfer_mode_e mode,
    input  logic       last_word,
    output logic       bus_req,
    output logic       write_fire,
    output logic       busy
);
    seq_state_e st;
    logic       had_gnt;

    assign bus_req    = (st == ST_OWN);
    assign busy       = (st != ST_IDLE);
    assign write_fire = (st == ST_OWN) && bus_gnt && buf_full && slot_free(mode, cpu_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            had_gnt <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) st <= ST_FILL;
                end
                ST_FILL: begin
                    had_gnt <= 1'b0;
                    if (buf_full) st <= ST_OWN;
                end
                ST_OWN: begin
                    had_gnt <= had_gnt | bus_gnt;
                    if (write_fire && last_word)
                        st <= ST_IDLE;
                    else if (write_fire && yields_per_word(mode))
                        st <= ST_FILL;
                    else if (had_gnt && !bus_gnt)
                        st <= ST_FILL;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/xfer_dma.sv
module xfer_dma
    import dmx_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_slot,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          per_valid,
    output logic          per_ready,
    input  logic [DW-1:0] per_data,
    output logic [AW-1:0] per_addr,
    output logic          irq
);
    logic          go, busy, buf_full, wr_fire, fetch_fire, last_word, done_q;
    ctrl_t         ctrl_q;
    xfer_mode_e    mode_q;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] fetch_left;
    logic [DW-1:0] buf_q;

    assign mode_q     = ctrl_q.mode;
    assign per_ready  = busy && (fetch_left != '0) && (!buf_full || wr_fire);
    assign fetch_fire = per_ready && per_valid;
    assign mem_we     = wr_fire;
    assign mem_addr   = dst_q;
    assign mem_wdata  = buf_q;
    assign per_addr   = src_q;
    assign irq        = done_q;

    dmx_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy), .fetch_fire(fetch_fire), .write_fire(wr_fire), .go(go),
        .ctrl_q(ctrl_q), .src_q(src_q), .dst_q(dst_q), .fetch_left(fetch_left),
        .last_word(last_word), .done_q(done_q)
    );

    dmx_wordbuf #(.DW(DW)) u_buf (
        .clk(clk), .rst(rst), .take(fetch_fire), .data_in(per_data),
        .drain(wr_fire), .full(buf_full), .data_q(buf_q)
    );

    dmx_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .buf_full(buf_full), .bus_gnt(bus_gnt),
        .cpu_slot(cpu_slot), .mode(mode_q), .last_word(last_word),
        .bus_req(bus_req), .write_fire(wr_fire), .busy(busy)
    );

endmodule

// File: rtl/xfer_dma_chk.sv
module xfer_dma_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic       mem_we,
    input logic       cpu_slot,
    input logic [1:0] mode,
    input logic       buf_full,
    input logic       irq,
    input logic       busy,
    input logic       cfg_we,
    input logic [1:0] cfg_sel,
    input logic       clr_bit
);
    AST_WRITE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (bus_req && bus_gnt)); // R1

    AST_HOLD_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_req) && $past(bus_gnt) && (mode == 2'b00 || mode == 2'b11)) |-> irq); // R2

    AST_YIELD_GIVES_BACK: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mode == 2'b01) |=> !bus_req); // R3

    AST_REQ_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> buf_full); // R4

    AST_SHARE_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mode == 2'b10) |-> !cpu_slot); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !(cfg_we && !busy && cfg_sel == 2'd3 && clr_bit)) |=> irq); // R7

    AST_PREEMPT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_gnt && $past(bus_req && bus_gnt)) |=> !bus_req); // R8

endmodule

bind xfer_dma xfer_dma_chk u_chk (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we),
    .cpu_slot(cpu_slot), .mode(mode_q), .buf_full(buf_full), .irq(irq), .busy(busy),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .clr_bit(cfg_wdata[5])
);

// File: tb/xfer_dma_test.sv
`timescale 1ns/1ps
module xfer_dma_test;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          bus_req, mem_we, per_ready, irq;
    logic          bus_gnt = 1'b0;
    logic          cpu_slot = 1'b0;
    logic          per_valid = 1'b0;
    logic [DW-1:0] per_data = '0;
    logic [AW-1:0] mem_addr, per_addr;
    logic [DW-1:0] mem_wdata;

    xfer_dma #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .cpu_slot(cpu_slot), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .per_valid(per_valid),
        .per_ready(per_ready), .per_data(per_data), .per_addr(per_addr), .irq(irq)
    );

    always #4 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    bit ended = 0;

    // monitor state
    int cyc = 0;
    bit mon_on = 0;
    int cur_L = 0, cur_mode = 0, seed_g = 0;
    bit gap_en = 0;
    int force_at = -1, force_len = 0, force_cnt = 0;
    int k_fetch = 0, nwr = 0, req_rises = 0, first_rise = 0, req_fall = 0;
    int irq_rise = 0, req_age = 0, gnt_viol = 0, slot_viol = 0, yield_viol = 0;
    bit saw_drop = 0, prev_req = 0, prev_irq = 0, prev_we = 0;
    logic [AW-1:0] wr_addr [64];
    logic [DW-1:0] wr_data [64];
    int            wr_cyc  [64];
    logic [AW-1:0] pa_log  [64];

    function automatic logic [DW-1:0] pat(input int s, input int k);
        return DW'(s * 257 + k * 29 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        k_fetch = 0; nwr = 0; req_rises = 0; first_rise = 0; req_fall = 0;
        irq_rise = 0; gnt_viol = 0; slot_viol = 0; yield_viol = 0; saw_drop = 0;
        force_cnt = 0;
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            per_data  = pat(seed_g, k_fetch);
            per_valid = gap_en ? cyc[0] : 1'b1;
            cpu_slot  = cyc[0];
            req_age   = bus_req ? req_age + 1 : 0;
            if (force_cnt > 0) begin
                bus_gnt = 1'b0;
                force_cnt--;
                if (!bus_req) saw_drop = 1;
            end else begin
                bus_gnt = bus_req && (req_age > cur_L);
            end
            #1;
            if (per_valid && per_ready) begin
                if (k_fetch < 64) pa_log[k_fetch] = per_addr;
                k_fetch++;
            end
            if (bus_req && !prev_req) begin
                req_rises++;
                if (req_rises == 1) first_rise = cyc;
            end
            if (!bus_req && prev_req) req_fall = cyc;
            if (prev_we && cur_mode == 1 && bus_req) yield_viol++;
            if (irq && !prev_irq) irq_rise = cyc;
            if (mem_we) begin
                if (!bus_gnt || !bus_req) gnt_viol++;
                if (cur_mode == 2 && cpu_slot) slot_viol++;
                if (nwr < 64) begin
                    wr_addr[nwr] = mem_addr;
                    wr_data[nwr] = mem_wdata;
                    wr_cyc[nwr]  = cyc;
                end
                nwr++;
                if (nwr == force_at) begin
                    force_cnt = force_len;
                    force_at  = -1;
                end
            end
            prev_req = bus_req;
            prev_irq = irq;
            prev_we  = mem_we;
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk); #2;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic wait_irq(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk); #2;
            if (irq) break;
        end
    endtask

    task automatic check_block(input int n, input int incs, input logic [AW-1:0] src,
                               input logic [AW-1:0] dst, input int seed);
        int bad = 0, badp = 0;
        chk(k_fetch == n, "R4", "peripheral words taken", k_fetch, n);
        chk(nwr == n, "R6", "memory writes", nwr, n);
        chk(gnt_viol == 0, "R1", "writes without grant", gnt_viol, 0);
        for (int k = 0; k < n && k < 64; k++) begin
            if (wr_addr[k] != dst + AW'(incs[1] ? k : 0) || wr_data[k] != pat(seed, k)) bad++;
            if (pa_log[k] != src + AW'(incs[0] ? k : 0)) badp++;
        end
        chk(bad == 0, "R6", "write address/data mismatches", bad, 0);
        chk(badp == 0, "R6", "peripheral address mismatches", badp, 0);
        if (nwr >= 1 && nwr <= 64)
            chk(irq_rise == wr_cyc[nwr-1] + 1, "R7", "irq rise cycle", irq_rise, wr_cyc[nwr-1] + 1);
    endtask

    task automatic do_run(input int mode, input int n, input int lat, input int incs,
                          input bit gap, input int f_at, input int f_len, input int seed);
        logic [AW-1:0] src, dst;
        src = AW'(16'h0100 + seed);
        dst = AW'(16'h0400 + seed * 16);
        cur_L = lat; gap_en = gap; cur_mode = mode; seed_g = seed; force_len = f_len;
        cfg_write(2'd0, src);
        cfg_write(2'd1, dst);
        cfg_write(2'd2, AW'(n));
        clear_logs();
        force_at = f_at;
        cfg_write(2'd3, AW'(mode | (incs << 2) | (1 << 4)));
        wait_irq(800);
        chk(irq == 1'b1, "R7", "irq after block", int'(irq), 1);
        check_block(n, incs, src, dst, seed);
        if ((mode == 0 || mode == 3) && f_at < 0) begin
            chk(req_rises == 1, "R2", "hold-mode request count", req_rises, 1);
            if (!gap && nwr == n) begin
                chk(wr_cyc[0] == first_rise + lat, "R2", "first write cycle",
                    wr_cyc[0], first_rise + lat);
                chk(wr_cyc[n-1] - wr_cyc[0] == n - 1, "R2", "write span",
                    wr_cyc[n-1] - wr_cyc[0], n - 1);
                chk(req_fall - first_rise == lat + n, "R2", "request duration",
                    req_fall - first_rise, lat + n);
            end
        end
        if (mode == 1) begin
            chk(req_rises == n, "R3", "yield-mode request count", req_rises, n);
            chk(yield_viol == 0, "R3", "request held after a write", yield_viol, 0);
        end
        if (mode == 2) begin
            int adj = 0;
            for (int k = 1; k < n && k < 64; k++)
                if (wr_cyc[k] - wr_cyc[k-1] < 2) adj++;
            chk(slot_viol == 0, "R5", "writes in processor slot", slot_viol, 0);
            chk(adj == 0, "R5", "adjacent share-mode writes", adj, 0);
        end
        if (f_at >= 0) begin
            chk(saw_drop == 1'b1, "R8", "request dropped on withdrawal", int'(saw_drop), 1);
            chk(req_rises == 2, "R8", "requests around withdrawal", req_rises, 2);
        end
        repeat (4) @(negedge clk);
        #2;
        chk(irq == 1'b1, "R7", "irq held", int'(irq), 1);
        cfg_write(2'd3, AW'(1 << 5));
        chk(irq == 1'b0, "R7", "irq cleared", int'(irq), 0);
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        int run_id;
        logic [AW-1:0] keep_dst;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        chk(bus_req == 1'b0, "R10", "reset bus_req", int'(bus_req), 0);
        chk(mem_we == 1'b0, "R10", "reset mem_we", int'(mem_we), 0);
        chk(per_ready == 1'b0, "R10", "reset per_ready", int'(per_ready), 0);
        chk(irq == 1'b0, "R10", "reset irq", int'(irq), 0);
        mon_on = 1;

        // R9: start with zero count is ignored
        clear_logs();
        cfg_write(2'd2, '0);
        cfg_write(2'd3, AW'(16'h0010));
        repeat (8) @(negedge clk);
        #2;
        chk(req_rises == 0, "R9", "requests after zero-count start", req_rises, 0);
        chk(irq == 1'b0, "R9", "irq after zero-count start", int'(irq), 0);

        // Sweep: every mode, lengths, latencies, step bits, gapped peripheral
        run_id = 1;
        for (int m = 0; m < 4; m++)
            for (int ni = 0; ni < 3; ni++)
                for (int li = 0; li < 2; li++)
                    for (int ic = 0; ic < 4; ic++) begin
                        do_run(m, (ni == 0) ? 1 : (ni == 1) ? 3 : 6, li * 2, ic,
                               (ic == 1), -1, 0, run_id);
                        run_id++;
                    end

        // R8: grant withdrawn in hold and share modes
        do_run(0, 6, 1, 3, 0, 2, 3, 200);
        do_run(3, 5, 0, 2, 0, 1, 3, 201);
        do_run(2, 6, 0, 3, 0, 3, 4, 202);

        // R9: writes during a block are ignored
        keep_dst = AW'(16'h0700);
        cur_L = 8; gap_en = 0; cur_mode = 0; seed_g = 300;
        cfg_write(2'd0, AW'(16'h0030));
        cfg_write(2'd1, keep_dst);
        cfg_write(2'd2, AW'(4));
        clear_logs();
        cfg_write(2'd3, AW'(16'h001C));
        cfg_write(2'd1, AW'(16'h0900));
        cfg_write(2'd2, AW'(2));
        cfg_write(2'd3, AW'(16'h0011));
        wait_irq(800);
        check_block(4, 3, AW'(16'h0030), keep_dst, 300);
        chk(req_rises == 1, "R9", "mode unchanged by busy write", req_rises, 1);
        cfg_write(2'd3, AW'(1 << 5));

        // R9: count is zero after a finished block, so a bare start does nothing
        clear_logs();
        cfg_write(2'd3, AW'(16'h0010));
        repeat (8) @(negedge clk);
        #2;
        chk(req_rises == 0, "R9", "start with spent count", req_rises, 0);
        chk(nwr == 0, "R9", "writes with spent count", nwr, 0);

        finish_up();
    end

endmodule